// File: doc/BRIEF.md
# CPU Interrupt Pin Conditioner

This block stands between seven external processor input pins and the core's pending-interrupt and halt controls. Pin activity reaches it as a stream of events. Each event carries a pin index, a new level and a valid strobe, and at most one event is taken per clock. The block keeps a record of the last accepted level of every pin and acts only when an event really changes that level. An event that repeats the stored level therefore produces nothing.

Each pin has its own sensitivity:
- The external and thermal interrupt pins are level-sensitive. Each drives its own pending flag.
- The soft-reset pin copies its level into a pending flag.
- The machine-check pin reacts only to a falling edge. That edge latches a request, and the request is held until the core acknowledges it.
- The checkstop pin drives the halt flag.
- The hard-reset and time-base-enable pins are recorded but have no other effect.

Top module: `irq_pin_cond`

## Requirements
- R1: Pin indices are 0 external, 1 thermal, 2 machine check, 3 checkstop, 4 hard reset, 5 soft reset, 6 time-base enable. Bit i of `pin_state_o` is the last accepted level of pin i. Reset clears `pin_state_o`, all pending flags and the halt flag.
- R2: An event whose level equals the stored bit of its pin is discarded. It causes no change to any output.
- R3: A change on pin 0 copies the new level into `pend_ext_o`.
- R4: A change on pin 1 copies the new level into `pend_therm_o`.
- R5: A 1-to-0 change on pin 2 sets `pend_mck_o`. A 0-to-1 change on pin 2 leaves it unchanged.
- R6: `pend_mck_o` is cleared only by `mck_ack_i`. If a set and an acknowledge fall in the same cycle, the set wins.
- R7: A change on pin 3 copies the new level into `halt_o`: level 1 halts the core and level 0 releases it.
- R8: A change on pin 5 copies the new level into `pend_srst_o`.
- R9: A change on pin 4 or pin 6 updates only its `pin_state_o` bit.
- R10: An event with index 7 is ignored. `pin_state_o` and all flags stay unchanged, apart from an acknowledge of the machine-check flag.
- R11: Every output reflects an accepted event from the clock edge that samples it. The latency is one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_valid_i | input | 1 | Event strobe |
| ev_pin_i | input | 3 | Pin index of the event |
| ev_level_i | input | 1 | New level of the pin |
| mck_ack_i | input | 1 | Core acknowledge of the machine-check request |
| pin_state_o | output | 7 | Last accepted level per pin |
| pend_ext_o | output | 1 | External interrupt pending |
| pend_therm_o | output | 1 | Thermal interrupt pending |
| pend_mck_o | output | 1 | Machine-check pending |
| pend_srst_o | output | 1 | Soft-reset pending |
| halt_o | output | 1 | Core halt request |

## Verification
Every result of an event or an acknowledge is due exactly one clock edge after the cycle that presents it, because each output is a single register stage. The bench drives each vector on a falling edge. It compares all outputs with its arithmetic model on the next falling edge, after exactly one rising edge. That point lies midway between the edge that should update the outputs and the edge that could disturb them.

The vectors cover every pin index with both levels, each applied twice so that repeats are exercised. They also include directed machine-check and acknowledge orderings and a long pseudo-random stream.

// File: rtl/irq_pin_pkg.sv
package irq_pin_pkg;
  parameter int unsigned NUM_PINS = 7;
  parameter int unsigned PIN_W    = 3;

  typedef enum logic [PIN_W-1:0] {
    PIN_EXT   = 3'd0,
    PIN_THERM = 3'd1,
    PIN_MCK   = 3'd2,
    PIN_CKSTP = 3'd3,
    PIN_HRST  = 3'd4,
    PIN_SRST  = 3'd5,
    PIN_TBEN  = 3'd6
  } pin_e;
endpackage

// File: rtl/irq_pin_state.sv
module irq_pin_state
  import irq_pin_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ev_valid_i,
  input  logic [PIN_W-1:0]    ev_pin_i,
  input  logic                ev_level_i,
  output logic [NUM_PINS-1:0] state_o,
  output logic [NUM_PINS-1:0] chg_o
);
  logic [NUM_PINS-1:0] state_q;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    // event hits this pin with a differing level
    assign chg_o[i] = ev_valid_i && (ev_pin_i == PIN_W'(i)) && (ev_level_i != state_q[i]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       state_q[i] <= 1'b0;
      else if (chg_o[i]) state_q[i] <= ev_level_i;
    end

    // R2
    no_repeat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev_valid_i && ev_pin_i == PIN_W'(i) && ev_level_i == state_q[i]) |=> $stable(state_q[i]));
  end

  assign state_o = state_q;

  // R10
  bad_index_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && ev_pin_i >= PIN_W'(NUM_PINS)) |=> $stable(state_q));
endmodule

// File: rtl/irq_pin_action.sv
module irq_pin_action
  import irq_pin_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] chg_i,
  input  logic                level_i,
  input  logic                mck_ack_i,
  output logic                pend_ext_o,
  output logic                pend_therm_o,
  output logic                pend_mck_o,
  output logic                pend_srst_o,
  output logic                halt_o
);
  logic ext_q, therm_q, mck_q, srst_q, halt_q;
  logic mck_set;

  assign mck_set = chg_i[PIN_MCK] && !level_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_q   <= 1'b0;
      therm_q <= 1'b0;
      mck_q   <= 1'b0;
      srst_q  <= 1'b0;
      halt_q  <= 1'b0;
    end else begin
      if (chg_i[PIN_EXT])   ext_q   <= level_i;
      if (chg_i[PIN_THERM]) therm_q <= level_i;
      if (chg_i[PIN_SRST])  srst_q  <= level_i;
      if (chg_i[PIN_CKSTP]) halt_q  <= level_i;
      // set takes precedence over acknowledge
      if (mck_set)          mck_q   <= 1'b1;
      else if (mck_ack_i)   mck_q   <= 1'b0;
    end
  end

  assign pend_ext_o   = ext_q;
  assign pend_therm_o = therm_q;
  assign pend_mck_o   = mck_q;
  assign pend_srst_o  = srst_q;
  assign halt_o       = halt_q;

  // R3
  ext_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_i[PIN_EXT] |=> (ext_q == $past(level_i)));
  // R5
  mck_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg_i[PIN_MCK] && !level_i) |=> mck_q);
  // R6
  mck_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mck_q && !mck_ack_i) |=> mck_q);
  // R7
  halt_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_i[PIN_CKSTP] |=> (halt_q == $past(level_i)));
endmodule

// File: rtl/irq_pin_cond.sv
module irq_pin_cond
  import irq_pin_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ev_valid_i,
  input  logic [PIN_W-1:0]    ev_pin_i,
  input  logic                ev_level_i,
  input  logic                mck_ack_i,
  output logic [NUM_PINS-1:0] pin_state_o,
  output logic                pend_ext_o,
  output logic                pend_therm_o,
  output logic                pend_mck_o,
  output logic                pend_srst_o,
  output logic                halt_o
);
  logic [NUM_PINS-1:0] chg;

  irq_pin_state u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ev_valid_i (ev_valid_i),
    .ev_pin_i   (ev_pin_i),
    .ev_level_i (ev_level_i),
    .state_o    (pin_state_o),
    .chg_o      (chg)
  );

  irq_pin_action u_action (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .chg_i        (chg),
    .level_i      (ev_level_i),
    .mck_ack_i    (mck_ack_i),
    .pend_ext_o   (pend_ext_o),
    .pend_therm_o (pend_therm_o),
    .pend_mck_o   (pend_mck_o),
    .pend_srst_o  (pend_srst_o),
    .halt_o       (halt_o)
  );

  // R10
  bad_index_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && ev_pin_i == 3'd7 && !mck_ack_i) |=>
      $stable({pend_ext_o, pend_therm_o, pend_mck_o, pend_srst_o, halt_o}));
  // R9
  passive_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && (ev_pin_i == 3'd4 || ev_pin_i == 3'd6) && !mck_ack_i) |=>
      $stable({pend_ext_o, pend_therm_o, pend_mck_o, pend_srst_o, halt_o}));
endmodule

// File: tb/tb_irq_pin_cond.sv
`timescale 1ns/1ps
module tb_irq_pin_cond;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_valid = 1'b0;
  logic [2:0] ev_pin = 3'd0;
  logic       ev_level = 1'b0;
  logic       mck_ack = 1'b0;
  logic [6:0] pin_state;
  logic       p_ext, p_therm, p_mck, p_srst, halt;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [6:0] m_st;
  logic m_ext, m_therm, m_mck, m_srst, m_halt;

  always #2.5 clk = ~clk;

  irq_pin_cond dut (
    .clk_i(clk), .rst_ni(rst_n), .ev_valid_i(ev_valid), .ev_pin_i(ev_pin),
    .ev_level_i(ev_level), .mck_ack_i(mck_ack), .pin_state_o(pin_state),
    .pend_ext_o(p_ext), .pend_therm_o(p_therm), .pend_mck_o(p_mck),
    .pend_srst_o(p_srst), .halt_o(halt)
  );

  task automatic compare(input string tag);
    vectors++;
    if (pin_state !== m_st) begin
      errors++;
      $display("FAIL R1/R2/R9/R10 %s pin_state act=%b exp=%b", tag, pin_state, m_st);
    end
    if (p_ext !== m_ext) begin
      errors++;
      $display("FAIL R3 %s pend_ext act=%b exp=%b", tag, p_ext, m_ext);
    end
    if (p_therm !== m_therm) begin
      errors++;
      $display("FAIL R4 %s pend_therm act=%b exp=%b", tag, p_therm, m_therm);
    end
    if (p_mck !== m_mck) begin
      errors++;
      $display("FAIL R5/R6 %s pend_mck act=%b exp=%b", tag, p_mck, m_mck);
    end
    if (p_srst !== m_srst) begin
      errors++;
      $display("FAIL R8 %s pend_srst act=%b exp=%b", tag, p_srst, m_srst);
    end
    if (halt !== m_halt) begin
      errors++;
      $display("FAIL R7 %s halt act=%b exp=%b", tag, halt, m_halt);
    end
  endtask

  // one vector: drive on negedge, result due after one rising edge (R11)
  task automatic apply(input logic v, input logic [2:0] p, input logic l,
                       input logic a, input string tag);
    logic mset;
    @(negedge clk);
    ev_valid = v; ev_pin = p; ev_level = l; mck_ack = a;
    mset = 1'b0;
    if (v && p < 3'd7 && m_st[p] != l) begin
      m_st[p] = l;
      case (p)
        3'd0: m_ext   = l;
        3'd1: m_therm = l;
        3'd2: mset    = !l;
        3'd3: m_halt  = l;
        3'd5: m_srst  = l;
        default: ;
      endcase
    end
    if (mset)   m_mck = 1'b1;
    else if (a) m_mck = 1'b0;
    @(negedge clk);
    ev_valid = 1'b0; mck_ack = 1'b0;
    compare(tag);
  endtask

  initial begin
    #(5ns * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    m_st = '0; m_ext = 0; m_therm = 0; m_mck = 0; m_srst = 0; m_halt = 0;
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after release");

    // sweep: every index, both levels, each twice (R2 repeats, R10 index 7)
    for (int p = 0; p < 8; p++) begin
      for (int l = 1; l >= 0; l--) begin
        apply(1'b1, 3'(p), 1'(l), 1'b0, "sweep first");
        apply(1'b1, 3'(p), 1'(l), 1'b0, "sweep repeat R2");
      end
    end

    // R5: rising edge alone does not set, falling does
    apply(1'b1, 3'd2, 1'b0, 1'b1, "R6 ack clear");
    apply(1'b1, 3'd2, 1'b1, 1'b0, "R5 rise no set");
    apply(1'b1, 3'd2, 1'b0, 1'b0, "R5 fall set");
    apply(1'b1, 3'd2, 1'b0, 1'b0, "R2 repeated low no event");
    apply(1'b1, 3'd2, 1'b1, 1'b0, "R6 pin rise no clear");
    apply(1'b1, 3'd2, 1'b0, 1'b1, "R6 set beats ack");
    apply(1'b1, 3'd7, 1'b1, 1'b0, "R10 index 7 ignored");
    apply(1'b0, 3'd2, 1'b1, 1'b1, "R6 ack clears");
    // R7 / R9 directed
    apply(1'b1, 3'd3, 1'b1, 1'b0, "R7 halt");
    apply(1'b1, 3'd4, 1'b1, 1'b0, "R9 hard reset state only");
    apply(1'b1, 3'd6, 1'b1, 1'b0, "R9 tben state only");
    apply(1'b1, 3'd3, 1'b0, 1'b0, "R7 release");
    apply(1'b0, 3'd0, 1'b1, 1'b0, "R11 no strobe");

    lfsr = 16'hACE1;
    for (int n = 0; n < 2000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      apply(lfsr[6] | lfsr[7], lfsr[2:0], lfsr[3], lfsr[4] & lfsr[5], "random R3 R4 R8");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule